// File: doc/BRIEF.md
# Electron-Photon Tower Cluster Finder

This block looks at a 3x3 window of calorimeter trigger towers, centred on the tower under test, and decides whether the centre seeds an electron or photon candidate. Each tower brings an 8-bit electromagnetic ET and an 8-bit hadronic ET. The candidate energy is the best two-tower electromagnetic sum that uses the centre and one of its four edge-sharing neighbours. The block reports that energy and which neighbour gave it. It also reports three flags: whether the centre is a local maximum, whether every tower in the window passes a hadronic-fraction cut, and whether the window is isolated.

A regional trigger instantiates the block once per tower position. It presents one window per clock, with `inValid` marking a real window. Two configuration inputs travel with the window: the shift that sets the hadronic-fraction divisor and the isolation threshold. All results come out three register stages later, aligned with `outValid`. Towers have single-tower granularity, so the neighbour code is the candidate's position refinement around the centre.

Top module: `egClusterTop`

## Requirements
- R1: A window sampled with `inValid` high at rising edge t produces its results, and `outValid` high, right after rising edge t+2. A new window is accepted on every clock. When `inValid` is low, `outValid` goes low three edges later and the result outputs keep their previous values.
- R2: Tower i (row-major, i = row*3+col, centre i = 4) occupies bits [8i+7:8i] of `emEt` and `hadEt`. `candEt` is the largest of the four sums of the centre EM ET with the EM ET of tower 1, 3, 5 or 7, saturated at 255.
- R3: `candPos` names the neighbour that gave the largest sum: 0 = tower 1, 1 = tower 3, 2 = tower 5, 3 = tower 7. When sums are equal, the lowest code wins.
- R4: `hadPass` is 1 only if, for every one of the nine towers, the hadronic ET shifted left by `cutShift` is at most its EM ET. No bits are lost in the shift.
- R5: The isolation sum is the total of EM plus hadronic ET over all nine towers, saturated at 4095. `isoPass` is 1 only if that sum minus `candEt` is strictly below `isoThresh`.
- R6: `candValid` is 1 only if the centre EM ET is strictly greater than that of towers 0 to 3, and greater than or equal to that of towers 5 to 8.
- R7: While `rstN` is low at a rising edge, all outputs are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Window on the inputs is real |
| emEt | input | 72 | Nine 8-bit EM tower ETs, tower i at [8i+7:8i] |
| hadEt | input | 72 | Nine 8-bit hadronic tower ETs, same layout |
| cutShift | input | 3 | Left shift applied to hadronic ET in the cut |
| isoThresh | input | 12 | Isolation threshold |
| outValid | output | 1 | Results below belong to a real window |
| candEt | output | 8 | Best pair EM ET, saturated |
| candPos | output | 2 | Neighbour code of the best pair |
| candValid | output | 1 | Centre is a local maximum |
| hadPass | output | 1 | All nine towers pass the hadronic cut |
| isoPass | output | 1 | Window is isolated |

## Verification
The hardest case to reach is one where saturation changes a flag. A window of nine all-ones towers with a large threshold does this: the raw isolation sum of 4590 would fail the cut, while the clamped 4095 passes. The same window also drives the pair sum past 255. Tie handling is the other subtle path. It is reached with windows in which the centre exactly equals a lower-index or a higher-index tower, and in which two opposite neighbours give the same pair sum. Vectors are streamed back to back so that each pipeline stage holds a different window at the same time.

// File: rtl/egClusterPkg.sv
package egClusterPkg;
  localparam int NTWR   = 9;
  localparam int CENTER = 4;
  localparam int NNB    = 4;

  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
  } egStrobe_t;

  // edge-sharing neighbour k of the centre: towers 1,3,5,7
  function automatic int nbIdx(input int k);
    return 2 * k + 1;
  endfunction
endpackage

// File: rtl/egClusterCtrl.sv
module egClusterCtrl
  import egClusterPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output egStrobe_t stb,
  output logic      outValid
);
  logic v1, v2, v3;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      v1 <= inValid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  always_comb begin
    stb.ld1 = inValid;
    stb.ld2 = v1;
    stb.ld3 = v2;
  end

  assign outValid = v3;
endmodule

// File: rtl/egClusterDp.sv
module egClusterDp
  import egClusterPkg::*;
#(
  parameter int ET_W    = 8,
  parameter int SUM_W   = 12,
  parameter int SHIFT_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  egStrobe_t             stb,
  input  logic [NTWR*ET_W-1:0]  emEt,
  input  logic [NTWR*ET_W-1:0]  hadEt,
  input  logic [SHIFT_W-1:0]    cutShift,
  input  logic [SUM_W-1:0]      isoThresh,
  output logic [ET_W-1:0]       candEt,
  output logic [1:0]            candPos,
  output logic                  candValid,
  output logic                  hadPass,
  output logic                  isoPass
);
  localparam int PAIR_W = ET_W + 1;
  localparam int SH_W   = ET_W + (1 << SHIFT_W) - 1;
  localparam int RAW_W  = ET_W + 1 + 4;
  localparam logic [SUM_W-1:0] SUM_MAX = {SUM_W{1'b1}};

  // ---------------- stage 1: per-tower work ----------------
  logic [ET_W-1:0]   em   [NTWR];
  logic [ET_W-1:0]   had  [NTWR];
  logic [PAIR_W-1:0] comb [NTWR];
  logic [NTWR-1:0]   cutOk;
  logic [NTWR-1:0]   lmBit;
  logic [PAIR_W-1:0] pair [NNB];

  for (genvar i = 0; i < NTWR; i++) begin : g_twr
    logic [SH_W-1:0] hadShifted;
    assign em[i]      = emEt[i*ET_W +: ET_W];
    assign had[i]     = hadEt[i*ET_W +: ET_W];
    assign comb[i]    = {1'b0, em[i]} + {1'b0, had[i]};
    assign hadShifted = SH_W'(had[i]) << cutShift;
    assign cutOk[i]   = hadShifted <= SH_W'(em[i]);
    if (i == CENTER) begin : g_self
      assign lmBit[i] = 1'b1;
    end else if (i < CENTER) begin : g_lo
      assign lmBit[i] = em[CENTER] > em[i];
    end else begin : g_hi
      assign lmBit[i] = em[CENTER] >= em[i];
    end
  end

  for (genvar k = 0; k < NNB; k++) begin : g_pair
    assign pair[k] = {1'b0, em[CENTER]} + {1'b0, em[nbIdx(k)]};
  end

  logic [PAIR_W-1:0] s1Comb [NTWR];
  logic [PAIR_W-1:0] s1Pair [NNB];
  logic              s1Cut, s1Lm;
  logic [SUM_W-1:0]  s1Thresh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NTWR; i++) s1Comb[i] <= '0;
      for (int k = 0; k < NNB; k++)  s1Pair[k] <= '0;
      s1Cut    <= 1'b0;
      s1Lm     <= 1'b0;
      s1Thresh <= '0;
    end else if (stb.ld1) begin
      for (int i = 0; i < NTWR; i++) s1Comb[i] <= comb[i];
      for (int k = 0; k < NNB; k++)  s1Pair[k] <= pair[k];
      s1Cut    <= &cutOk;
      s1Lm     <= &lmBit;
      s1Thresh <= isoThresh;
    end
  end

  // ---------------- stage 2: window sum, best pair ----------------
  logic [RAW_W-1:0]  rawSum;
  logic [SUM_W-1:0]  satSum;
  logic [PAIR_W-1:0] best;
  logic [1:0]        bestK;
  logic [ET_W-1:0]   bestSat;

  always_comb begin
    rawSum = '0;
    for (int i = 0; i < NTWR; i++) rawSum = rawSum + RAW_W'(s1Comb[i]);
    satSum = (rawSum > RAW_W'(SUM_MAX)) ? SUM_MAX : rawSum[SUM_W-1:0];
  end

  always_comb begin
    best  = s1Pair[0];
    bestK = 2'd0;
    for (int k = 1; k < NNB; k++) begin
      if (s1Pair[k] > best) begin
        best  = s1Pair[k];
        bestK = 2'(k);
      end
    end
    bestSat = best[ET_W] ? {ET_W{1'b1}} : best[ET_W-1:0];
  end

  logic [SUM_W-1:0] s2Sum, s2Thresh;
  logic [ET_W-1:0]  s2Cand;
  logic [1:0]       s2Pos;
  logic             s2Lm, s2Cut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s2Sum    <= '0;
      s2Thresh <= '0;
      s2Cand   <= '0;
      s2Pos    <= '0;
      s2Lm     <= 1'b0;
      s2Cut    <= 1'b0;
    end else if (stb.ld2) begin
      s2Sum    <= satSum;
      s2Thresh <= s1Thresh;
      s2Cand   <= bestSat;
      s2Pos    <= bestK;
      s2Lm     <= s1Lm;
      s2Cut    <= s1Cut;
    end
  end

  // ---------------- stage 3: isolation, outputs ----------------
  logic [SUM_W-1:0] isoDiff;
  assign isoDiff = s2Sum - SUM_W'(s2Cand);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      candEt    <= '0;
      candPos   <= '0;
      candValid <= 1'b0;
      hadPass   <= 1'b0;
      isoPass   <= 1'b0;
    end else if (stb.ld3) begin
      candEt    <= s2Cand;
      candPos   <= s2Pos;
      candValid <= s2Lm;
      hadPass   <= s2Cut;
      isoPass   <= isoDiff < s2Thresh;
    end
  end
endmodule

// File: rtl/egClusterTop.sv
module egClusterTop
  import egClusterPkg::*;
#(
  parameter int ET_W    = 8,
  parameter int SUM_W   = 12,
  parameter int SHIFT_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [9*ET_W-1:0]     emEt,
  input  logic [9*ET_W-1:0]     hadEt,
  input  logic [SHIFT_W-1:0]    cutShift,
  input  logic [SUM_W-1:0]      isoThresh,
  output logic                  outValid,
  output logic [ET_W-1:0]       candEt,
  output logic [1:0]            candPos,
  output logic                  candValid,
  output logic                  hadPass,
  output logic                  isoPass
);
  egStrobe_t stb;

  egClusterCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  egClusterDp #(
    .ET_W    (ET_W),
    .SUM_W   (SUM_W),
    .SHIFT_W (SHIFT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .emEt      (emEt),
    .hadEt     (hadEt),
    .cutShift  (cutShift),
    .isoThresh (isoThresh),
    .candEt    (candEt),
    .candPos   (candPos),
    .candValid (candValid),
    .hadPass   (hadPass),
    .isoPass   (isoPass)
  );
endmodule

// File: rtl/egClusterChk.sv
module egClusterChk #(
  parameter int ET_W    = 8,
  parameter int SUM_W   = 12,
  parameter int SHIFT_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [9*ET_W-1:0]  emEt,
  input logic [9*ET_W-1:0]  hadEt,
  input logic [SHIFT_W-1:0] cutShift,
  input logic [SUM_W-1:0]   isoThresh,
  input logic               outValid,
  input logic [ET_W-1:0]    candEt,
  input logic [1:0]         candPos,
  input logic               candValid,
  input logic               hadPass,
  input logic               isoPass
);
  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  a_r1_latency: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (outValid == $past(inValid, 3)));

  a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && !$past(inValid, 3)) |-> ($stable(candEt) && $stable(candPos) && $stable(isoPass)));

  a_r2_cand_covers_centre: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && outValid) |-> (candEt >= $past(emEt[4*ET_W +: ET_W], 3)));

  a_r4_no_hadronic: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && outValid && $past(hadEt, 3) == '0) |-> hadPass);

  a_r5_zero_thresh: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && outValid && $past(isoThresh, 3) == '0) |-> !isoPass);

  a_r6_empty_centre: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && outValid && $past(emEt[4*ET_W +: ET_W], 3) == '0) |-> !candValid);

  a_r7_reset_clears: assert property (@(posedge clk)
    !rstN |=> (!outValid && candEt == '0 && candPos == 2'd0 && !candValid && !hadPass && !isoPass));
endmodule

bind egClusterTop egClusterChk #(
  .ET_W    (ET_W),
  .SUM_W   (SUM_W),
  .SHIFT_W (SHIFT_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .emEt      (emEt),
  .hadEt     (hadEt),
  .cutShift  (cutShift),
  .isoThresh (isoThresh),
  .outValid  (outValid),
  .candEt    (candEt),
  .candPos   (candPos),
  .candValid (candValid),
  .hadPass   (hadPass),
  .isoPass   (isoPass)
);

// File: tb/tb_egClusterTop.sv
`timescale 1ns/1ps
module tb_egClusterTop;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [71:0] emEt, hadEt;
  logic [2:0]  cutShift;
  logic [11:0] isoThresh;
  logic        outValid, candValid, hadPass, isoPass;
  logic [7:0]  candEt;
  logic [1:0]  candPos;

  always #2 clk = ~clk;

  egClusterTop dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .emEt(emEt), .hadEt(hadEt),
    .cutShift(cutShift), .isoThresh(isoThresh), .outValid(outValid),
    .candEt(candEt), .candPos(candPos), .candValid(candValid),
    .hadPass(hadPass), .isoPass(isoPass)
  );

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [71:0] em;
    logic [71:0] had;
    logic [7:0]  et;
    logic [1:0]  pos;
    logic        cv;
    logic        hp;
    logic        ip;
  } vec_t;

  // towers listed 8..0, two hex digits each; shift 3, threshold 20
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{72'h00_00_00_00_00_00_00_00_00, 72'h0,                          8'h00, 2'd0, 1'b0, 1'b1, 1'b1},
    '{72'h00_00_00_20_40_00_00_00_00, 72'h0,                          8'h60, 2'd2, 1'b1, 1'b1, 1'b1},
    '{72'h00_10_00_00_40_00_00_10_30, 72'h0,                          8'h50, 2'd0, 1'b1, 1'b1, 1'b0},
    '{72'h07_00_00_00_40_00_00_00_00, 72'h01_00_00_00_00_00_00_00_00, 8'h40, 2'd0, 1'b1, 1'b0, 1'b1},
    '{72'h08_00_00_00_40_00_00_00_00, 72'h01_00_00_00_00_00_00_00_00, 8'h40, 2'd0, 1'b1, 1'b1, 1'b1},
    '{72'h00_00_00_00_40_40_00_00_00, 72'h0,                          8'h80, 2'd1, 1'b0, 1'b1, 1'b1},
    '{72'h00_00_00_40_40_00_00_00_00, 72'h0,                          8'h80, 2'd2, 1'b1, 1'b1, 1'b1},
    '{72'hFF_FF_FF_FF_FF_FF_FF_FF_FF, 72'hFF_FF_FF_FF_FF_FF_FF_FF_FF, 8'hFF, 2'd0, 1'b0, 1'b0, 1'b0}
  };

  task automatic runOne(input logic [71:0] e, input logic [71:0] h,
                        input logic [2:0] sh, input logic [11:0] th);
    @(negedge clk);
    emEt = e; hadEt = h; cutShift = sh; isoThresh = th; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; emEt = '0; hadEt = '0; cutShift = 3'd3; isoThresh = 12'd20;
    repeat (3) @(negedge clk);
    // R7 reset state
    check("R7 outValid", int'(outValid), 0);
    check("R7 candEt", int'(candEt), 0);
    check("R7 flags", int'({candValid, hadPass, isoPass}), 0);
    rstN = 1'b1;

    // streamed table, one window per clock
    for (int n = 0; n < NV + 3; n++) begin
      @(negedge clk);
      if (n >= 3) begin
        check("R1 outValid", int'(outValid), 1);
        check("R2 candEt", int'(candEt), int'(VECS[n-3].et));
        check("R3 candPos", int'(candPos), int'(VECS[n-3].pos));
        check("R6 candValid", int'(candValid), int'(VECS[n-3].cv));
        check("R4 hadPass", int'(hadPass), int'(VECS[n-3].hp));
        check("R5 isoPass", int'(isoPass), int'(VECS[n-3].ip));
      end
      if (n < NV) begin
        emEt = VECS[n].em; hadEt = VECS[n].had; cutShift = 3'd3; isoThresh = 12'd20;
        inValid = 1'b1;
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    check("R1 outValid drops", int'(outValid), 0);

    // R4 shift 0 boundary: had == em passes, shift 1 fails
    runOne(72'h00_00_00_00_40_00_00_00_05, 72'h00_00_00_00_00_00_00_00_05, 3'd0, 12'd100);
    check("R4 shift0 equal", int'(hadPass), 1);
    runOne(72'h00_00_00_00_40_00_00_00_05, 72'h00_00_00_00_00_00_00_00_05, 3'd1, 12'd100);
    check("R4 shift1", int'(hadPass), 0);

    // R5 strict threshold: residual 64
    runOne(VECS[2].em, 72'h0, 3'd3, 12'd64);
    check("R5 thresh equal", int'(isoPass), 0);
    runOne(VECS[2].em, 72'h0, 3'd3, 12'd65);
    check("R5 thresh above", int'(isoPass), 1);

    // R5 saturation: 4095-255=3840 < 4000 though raw 4590-255 is not
    runOne(VECS[7].em, VECS[7].had, 3'd3, 12'd4000);
    check("R5 saturated sum", int'(isoPass), 1);
    check("R2 saturated cand", int'(candEt), 255);

    // R1 hold: idle inputs with garbage leave results alone
    emEt = 72'h12_34_56_78_9A_BC_DE_F0_11;
    repeat (4) @(negedge clk);
    check("R1 hold candEt", int'(candEt), 255);
    check("R1 hold isoPass", int'(isoPass), 1);
    check("R1 idle outValid", int'(outValid), 0);

    // R7 reset mid-flight
    @(negedge clk);
    emEt = VECS[1].em; hadEt = '0; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 flush outValid", int'(outValid), 0);
    check("R7 flush candEt", int'(candEt), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule